// File: doc/BRIEF.md
# Pipelined 32x32 Multiplier with Signed/Unsigned Mode and Half Select

This block multiplies two 32-bit operands in a three-register pipeline and takes a new operation on every clock, so a rotating multi-thread datapath can issue to it each cycle without ever stalling. Each operation picks its own arithmetic mode, unsigned or two's complement, and its own result half, the lower or the upper 32 bits of the 64-bit product. A small thread tag and a valid bit travel through the pipeline with the operands, so the result comes back labelled with the thread that asked for it.

Internally, each operand is widened by one bit, with its sign bit in signed mode and a zero in unsigned mode. The widened values are then multiplied as signed numbers. The first stage registers partial products of 16-bit slices. The second stage adds them into the 64-bit product. The third stage keeps the requested half and registers the outputs. No vendor arithmetic primitive is used.

Top module: `mulp_top`

## Requirements
- R1: While reset is asserted, and after it until the first operation emerges, out_valid, result and tag_out are all zero.
- R2: An operation presented with in_valid=1 at a rising edge appears with out_valid=1 right after the second rising edge that follows. That is a fixed three-register latency, with one operation accepted on every clock.
- R3: tag_out carries the tag_in value of the operation whose result is on result.
- R4: With is_signed=0 (unsigned) and hi_sel=0 (lower half), result is bits 31:0 of the unsigned 64-bit product.
- R5: With is_signed=0 and hi_sel=1 (upper half), result is bits 63:32 of the unsigned product.
- R6: With is_signed=1 (two's complement) and hi_sel=0, result is bits 31:0 of the signed 64-bit product.
- R7: With is_signed=1 and hi_sel=1, result is bits 63:32 of the signed product.
- R8: Signed corner cases hold. 0x80000000 times 0x80000000 gives upper 0x40000000 and lower 0x00000000. 0xFFFFFFFF times 0xFFFFFFFF gives upper 0x00000000 and lower 0x00000001. 0x80000000 times 0x00000001 gives upper 0xFFFFFFFF and lower 0x80000000.
- R9: In unsigned mode, 0xFFFFFFFF times 0xFFFFFFFF gives upper 0xFFFFFFFE and lower 0x00000001.
- R10: Operations issued on consecutive clocks, with mode, half and tag changing each clock, each return their own correct result, in issue order.
- R11: On a clock where no operation emerges, out_valid is 0 and result and tag_out keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is presented this clock |
| a | input | 32 | Multiplicand |
| b | input | 32 | Multiplier |
| is_signed | input | 1 | 1 = two's complement operands, 0 = unsigned |
| hi_sel | input | 1 | 1 = return product bits 63:32, 0 = bits 31:0 |
| tag_in | input | 3 | Thread tag of the operation |
| out_valid | output | 1 | result and tag_out hold a new operation |
| result | output | 32 | Selected half of the product |
| tag_out | output | 3 | Tag of the operation on result |

## Verification
The result of an operation driven on clock cycle c is due at the sample point of cycle c+3. That point falls after the third rising edge, counting the edge that captures the operands. Each scoreboard entry records its due cycle, and the monitor samples on falling edges. It compares the cycle number as well as the value and the tag, so a result that arrives early or late fails even when its value is right. On cycles where nothing is due, the monitor checks that out_valid is low and that the result and tag outputs hold their previous values.

// File: rtl/mulp_pkg.sv
package mulp_pkg;
  // default geometry of the multiplier
  localparam int unsigned DEF_OP_W  = 32;
  localparam int unsigned DEF_SLICE = 16;
  localparam int unsigned DEF_TAG_W = 3;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;

  typedef enum logic {
    MODE_UNSIGNED = 1'b0,
    MODE_SIGNED   = 1'b1
  } mode_e;
endpackage

// File: rtl/mulp_ppgen.sv
module mulp_ppgen #(
  parameter int unsigned OP_W  = mulp_pkg::DEF_OP_W,
  parameter int unsigned SLICE = mulp_pkg::DEF_SLICE,
  parameter int unsigned TAG_W = mulp_pkg::DEF_TAG_W,
  localparam int unsigned EXT_W = OP_W + 1,
  localparam int unsigned NSL   = (EXT_W + SLICE - 1) / SLICE,
  localparam int unsigned PP_W  = 2 * SLICE + 2,
  localparam int unsigned NPP   = NSL * NSL
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [OP_W-1:0]            a,
  input  logic [OP_W-1:0]            b,
  input  logic                       is_signed,
  input  logic                       hi_sel,
  input  logic [TAG_W-1:0]           tag_in,
  output logic                       s1_valid,
  output logic                       s1_hi,
  output logic [TAG_W-1:0]           s1_tag,
  output logic [NPP-1:0][PP_W-1:0]   s1_pp
);
  localparam int unsigned XW = NSL * SLICE;

  // operands widened over the whole slice span: sign or zero fill
  logic [XW-1:0] ax, bx;
  assign ax = is_signed ? XW'($signed(a)) : XW'(a);
  assign bx = is_signed ? XW'($signed(b)) : XW'(b);

  // slices as signed SLICE+1 bit values: lower slices are unsigned,
  // the top slice carries the sign of the widened operand
  logic signed [SLICE:0] a_sl [NSL];
  logic signed [SLICE:0] b_sl [NSL];

  for (genvar g = 0; g < NSL; g++) begin : g_slice
    if (g == NSL - 1) begin : g_top
      assign a_sl[g] = {ax[g*SLICE+SLICE-1], ax[g*SLICE +: SLICE]};
      assign b_sl[g] = {bx[g*SLICE+SLICE-1], bx[g*SLICE +: SLICE]};
    end else begin : g_low
      assign a_sl[g] = {1'b0, ax[g*SLICE +: SLICE]};
      assign b_sl[g] = {1'b0, bx[g*SLICE +: SLICE]};
    end
  end

  logic signed [PP_W-1:0] pp_n [NPP];

  for (genvar gi = 0; gi < NSL; gi++) begin : g_row
    for (genvar gj = 0; gj < NSL; gj++) begin : g_col
      assign pp_n[gi*NSL+gj] = PP_W'(a_sl[gi]) * PP_W'(b_sl[gj]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_hi    <= 1'b0;
      s1_tag   <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_hi    <= hi_sel;
      s1_tag   <= tag_in;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NPP; k++) s1_pp[k] <= pp_n[k];
  end
endmodule

// File: rtl/mulp_sum.sv
module mulp_sum #(
  parameter int unsigned OP_W  = mulp_pkg::DEF_OP_W,
  parameter int unsigned SLICE = mulp_pkg::DEF_SLICE,
  parameter int unsigned TAG_W = mulp_pkg::DEF_TAG_W,
  localparam int unsigned EXT_W = OP_W + 1,
  localparam int unsigned NSL   = (EXT_W + SLICE - 1) / SLICE,
  localparam int unsigned PP_W  = 2 * SLICE + 2,
  localparam int unsigned NPP   = NSL * NSL,
  localparam int unsigned PR_W  = 2 * OP_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       s1_valid,
  input  logic                       s1_hi,
  input  logic [TAG_W-1:0]           s1_tag,
  input  logic [NPP-1:0][PP_W-1:0]   s1_pp,
  output logic                       s2_valid,
  output logic                       s2_hi,
  output logic [TAG_W-1:0]           s2_tag,
  output logic [PR_W-1:0]            s2_prod
);
  // sum of all weighted partial products, kept modulo 2^PR_W
  logic [PR_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int k = 0; k < NPP; k++) begin
      logic [PR_W-1:0] term;
      term = PR_W'($signed(s1_pp[k]));
      acc  = acc + (term << (SLICE * ((k / NSL) + (k % NSL))));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_hi    <= 1'b0;
      s2_tag   <= '0;
    end else begin
      s2_valid <= s1_valid;
      s2_hi    <= s1_hi;
      s2_tag   <= s1_tag;
    end
  end

  always_ff @(posedge clk) s2_prod <= acc;
endmodule

// File: rtl/mulp_out.sv
module mulp_out #(
  parameter int unsigned OP_W  = mulp_pkg::DEF_OP_W,
  parameter int unsigned TAG_W = mulp_pkg::DEF_TAG_W,
  localparam int unsigned PR_W = 2 * OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s2_valid,
  input  logic              s2_hi,
  input  logic [TAG_W-1:0]  s2_tag,
  input  logic [PR_W-1:0]   s2_prod,
  output logic              out_valid,
  output logic [OP_W-1:0]   result,
  output logic [TAG_W-1:0]  tag_out
);
  logic [OP_W-1:0] half_pick;
  assign half_pick = (s2_hi == mulp_pkg::HALF_HI) ? s2_prod[PR_W-1:OP_W]
                                                  : s2_prod[OP_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      tag_out   <= '0;
    end else begin
      out_valid <= s2_valid;
      if (s2_valid) begin
        result  <= half_pick;
        tag_out <= s2_tag;
      end
    end
  end
endmodule

// File: rtl/mulp_top.sv
module mulp_top #(
  parameter int unsigned OP_W  = mulp_pkg::DEF_OP_W,
  parameter int unsigned SLICE = mulp_pkg::DEF_SLICE,
  parameter int unsigned TAG_W = mulp_pkg::DEF_TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   a,
  input  logic [OP_W-1:0]   b,
  input  logic              is_signed,
  input  logic              hi_sel,
  input  logic [TAG_W-1:0]  tag_in,
  output logic              out_valid,
  output logic [OP_W-1:0]   result,
  output logic [TAG_W-1:0]  tag_out
);
  localparam int unsigned EXT_W = OP_W + 1;
  localparam int unsigned NSL   = (EXT_W + SLICE - 1) / SLICE;
  localparam int unsigned PP_W  = 2 * SLICE + 2;
  localparam int unsigned NPP   = NSL * NSL;
  localparam int unsigned PR_W  = 2 * OP_W;

  // stage boundaries, named for the assertions
  logic                      s1_valid, s1_hi;
  logic [TAG_W-1:0]          s1_tag;
  logic [NPP-1:0][PP_W-1:0]  s1_pp;
  logic                      s2_valid, s2_hi;
  logic [TAG_W-1:0]          s2_tag;
  logic [PR_W-1:0]           s2_prod;

  mulp_ppgen #(.OP_W(OP_W), .SLICE(SLICE), .TAG_W(TAG_W)) u_ppgen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
    .is_signed(is_signed), .hi_sel(hi_sel), .tag_in(tag_in),
    .s1_valid(s1_valid), .s1_hi(s1_hi), .s1_tag(s1_tag), .s1_pp(s1_pp)
  );

  mulp_sum #(.OP_W(OP_W), .SLICE(SLICE), .TAG_W(TAG_W)) u_sum (
    .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_hi(s1_hi),
    .s1_tag(s1_tag), .s1_pp(s1_pp), .s2_valid(s2_valid), .s2_hi(s2_hi),
    .s2_tag(s2_tag), .s2_prod(s2_prod)
  );

  mulp_out #(.OP_W(OP_W), .TAG_W(TAG_W)) u_out (
    .clk(clk), .rst_n(rst_n), .s2_valid(s2_valid), .s2_hi(s2_hi),
    .s2_tag(s2_tag), .s2_prod(s2_prod), .out_valid(out_valid),
    .result(result), .tag_out(tag_out)
  );

  // reference arithmetic: plain full-width multiply of widened operands
  function automatic logic [PR_W-1:0] full_product(
    input logic [OP_W-1:0] x, input logic [OP_W-1:0] y, input logic sgn);
    logic [PR_W-1:0] xe, ye;
    xe = sgn ? PR_W'($signed(x)) : PR_W'(x);
    ye = sgn ? PR_W'($signed(y)) : PR_W'(y);
    return xe * ye;
  endfunction

  function automatic logic [OP_W-1:0] pick_half(
    input logic [PR_W-1:0] p, input logic hi);
    return hi ? p[PR_W-1:OP_W] : p[OP_W-1:0];
  endfunction

  // clocks since reset release, saturating at the pipeline depth
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (!rst_n)            warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'd3) |-> (!out_valid && result == '0 && tag_out == '0));

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R2
  stage_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> (s2_valid == $past(in_valid, 2)));

  // R3
  tag_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3 && out_valid) |-> (tag_out == $past(tag_in, 3)));

  // R4 R5 R6 R7
  product_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3 && out_valid) |->
      (result == pick_half(full_product($past(a, 3), $past(b, 3),
                                        $past(is_signed, 3)),
                           $past(hi_sel, 3))));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'd0 && !out_valid) |-> ($stable(result) && $stable(tag_out)));
endmodule

// File: tb/mulp_top_test.sv
module mulp_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        is_signed = 1'b0, hi_sel = 1'b0;
  logic [2:0]  tag_in = '0;
  logic        out_valid;
  logic [31:0] result;
  logic [2:0]  tag_out;

  always #4 clk = ~clk;  // 125 MHz

  mulp_top uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
    .is_signed(is_signed), .hi_sel(hi_sel), .tag_in(tag_in),
    .out_valid(out_valid), .result(result), .tag_out(tag_out)
  );

  typedef struct {
    logic [31:0] val;
    logic [2:0]  tag;
    int          due;
    string       req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   mon_on = 1'b0;
  logic [31:0] last_res = '0;
  logic [2:0]  last_tag = '0;

  always @(posedge clk) cyc <= cyc + 1;

  // expected value: the 64-bit product built from 64-bit integer arithmetic
  function automatic logic [31:0] model(logic [31:0] x, logic [31:0] y,
                                        logic sg, logic hi);
    longint p;
    logic [63:0] u;
    if (sg) begin
      p = longint'($signed(x)) * longint'($signed(y));
      u = 64'(p);
    end else begin
      u = {32'd0, x} * {32'd0, y};
    end
    return hi ? u[63:32] : u[31:0];
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: one operation per call, on the falling edge
  task automatic issue(logic [31:0] x, logic [31:0] y, logic sg, logic hi,
                       logic [2:0] t, string req);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; a = x; b = y; is_signed = sg; hi_sel = hi; tag_in = t;
    e.val = model(x, y, sg, hi);
    e.tag = t;
    e.due = cyc + 3;
    e.req = req;
    q.push_back(e);
  endtask

  task automatic bubble();
    @(negedge clk);
    in_valid = 1'b0;
    a = 32'hDEAD_BEEF; b = 32'h1234_5678; tag_in = 3'd7; hi_sel = 1'b1;
  endtask

  // monitor: compares outputs against the scoreboard on falling edges
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (q.size() == 0) begin
          check(1'b0, "R2 unexpected out_valid", {31'd0, out_valid}, 32'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(cyc == e.due, {e.req, " R2 cycle"}, 32'(cyc), 32'(e.due));
          check(result == e.val, e.req, result, e.val);
          check(tag_out == e.tag, {e.req, " R3 tag"}, {29'd0, tag_out}, {29'd0, e.tag});
        end
        last_res = result;
        last_tag = tag_out;
      end else begin
        if (q.size() != 0 && q[0].due <= cyc)
          check(1'b0, "R2 missing result", 32'd0, 32'd1);
        check(result == last_res && tag_out == last_tag, "R11 hold",
              result, last_res);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: outputs quiet during reset
    check(!out_valid && result == 0 && tag_out == 0, "R1 reset",
          result, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;
    @(negedge clk);
    check(!out_valid, "R1 after release", {31'd0, out_valid}, 32'd0);

    // R4 R5 unsigned basics
    issue(32'd7, 32'd6, 1'b0, 1'b0, 3'd1, "R4 7*6 lo");
    issue(32'h0001_0000, 32'h0001_0000, 1'b0, 1'b1, 3'd2, "R5 2^16*2^16 hi");
    issue(32'h1234_5678, 32'h9ABC_DEF0, 1'b0, 1'b0, 3'd3, "R4 mixed lo");
    issue(32'h1234_5678, 32'h9ABC_DEF0, 1'b0, 1'b1, 3'd4, "R5 mixed hi");
    // R6 R7 signed basics
    issue(32'hFFFF_FFFD, 32'd5, 1'b1, 1'b0, 3'd5, "R6 -3*5 lo");
    issue(32'hFFFF_FFFD, 32'd5, 1'b1, 1'b1, 3'd6, "R7 -3*5 hi");
    issue(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, 1'b1, 3'd0, "R7 max*max hi");
    bubble(); bubble(); bubble();
    // R8 signed corners
    issue(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b1, 3'd1, "R8 min*min hi");
    issue(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, 3'd2, "R8 min*min lo");
    issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1, 3'd3, "R8 -1*-1 hi");
    issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, 3'd4, "R8 -1*-1 lo");
    issue(32'h8000_0000, 32'd1, 1'b1, 1'b1, 3'd5, "R8 min*1 hi");
    issue(32'h8000_0000, 32'd1, 1'b1, 1'b0, 3'd6, "R8 min*1 lo");
    // R9 unsigned all ones
    issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, 3'd7, "R9 ones*ones hi");
    issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, 3'd0, "R9 ones*ones lo");
    issue(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1, 3'd1, "R5 2^31*2^31 hi");
    bubble(); bubble(); bubble(); bubble();
    // R10 back-to-back with changing mode, half and tag
    for (int i = 0; i < 300; i++) begin
      issue($urandom(), $urandom(), 1'(i % 2), 1'((i / 2) % 2), 3'(i),
            "R10 stream");
    end
    // R11 sparse issue with bubbles in between
    for (int i = 0; i < 40; i++) begin
      issue($urandom(), $urandom(), 1'(i % 3 == 0), 1'(i % 2), 3'(i + 3),
            "R11 sparse");
      repeat (i % 4) bubble();
    end
    bubble();
    repeat (6) @(negedge clk);
    check(q.size() == 0, "R2 drain", 32'(q.size()), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule